// File: doc/BRIEF.md
# Wide Register Byte Access Bridge

This block lets a byte-wide bus reach a bank of 16-bit registers, such as a timer's running count, its compare values and its capture value. Every register takes two byte addresses. A single 8-bit holding register is shared by the whole bank and carries the upper half of a wide transfer. Because of this sharing, each 16-bit value is moved as one unit even though the bus only carries one byte at a time.

To write a register, software first writes its upper byte, which only lands in the holding register. It then writes the lower byte, and in that cycle the bridge presents the combined 16-bit word and a one-cycle write enable to the target register. To read a register, software first reads its lower byte. That read freezes the register's upper byte in the holding register, and a later read of the upper byte address returns that frozen copy. Compare registers are an exception: their reads bypass the holding register.

Top module: `wide_reg_byte_bridge`

## Requirements
- R1: After reset the holding register is 0x00, so a read of the upper byte address of a non-compare register returns 0x00.
- R2: The byte address is {register index, byte select}. Byte select 0 is the lower byte and 1 is the upper byte. With default parameters index 0 is the counter, 1 and 2 are compare registers (mask 4'b0110), and 3 is the capture register.
- R3: A write to an upper byte address, for any register, loads the write data into the holding register and asserts no register write enable.
- R4: A write to a lower byte address asserts the target register's write enable for exactly that cycle. The write data presented is {holding register, write data}. No other write enable is asserted.
- R5: A read of a non-compare register's lower byte address returns that register's lower byte. At the clock edge it copies the register's upper byte into the holding register, so a later upper byte read returns the value from the time of the lower byte read, even if the register has changed since.
- R6: The upper byte address of a non-compare register reads back the holding register.
- R7: For a compare register, a read of the upper byte address returns the register's live upper byte, and a read of its lower byte address leaves the holding register unchanged.
- R8: The holding register is shared: an upper byte written through any register's address is used by the next lower byte write to any register.
- R9: A write and a read strobe in the same cycle on the same lower byte address of a non-compare register do two things. The write uses the holding register value from before the edge. The holding register then takes the register's upper byte from before the write.
- R10: Without a strobe, the holding register keeps its value and no write enable is asserted. Read data follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W (3) | Byte address {index, byte select} |
| wdata_i | input | 8 | Bus write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Read data, combinational from address |
| reg_wdata_o | output | 16*NUM_REGS | Per-register write data, register k at bits [16k+15:16k] |
| reg_we_o | output | NUM_REGS | Per-register one-cycle write enable |
| reg_val_i | input | 16*NUM_REGS | Per-register current value |

## Verification
The holding register has two users that can meet in one clock: a lower byte write consumes it and a lower byte read reloads it. The bench provokes this by raising both strobes together on the counter's lower byte address. It judges the write enable and data before the edge against the old holding value. After the edge it reads the upper byte address back and expects the counter's previous upper byte, not the newly written one.

// File: rtl/wrb_pkg.sv
package wrb_pkg;
  localparam int BYTE_W = 8;
  localparam int WIDE_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WIDE_W-1:0] wide_t;
endpackage

// File: rtl/wrb_decode.sv
module wrb_decode #(
  parameter int NUM_REGS = 4,
  parameter int IDX_W    = 2
) (
  input  logic [IDX_W:0]      addr_i,
  output logic                hit_o,
  output logic                high_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [NUM_REGS-1:0] sel_o
);
  localparam logic [IDX_W:0] NREGS = NUM_REGS[IDX_W:0];

  assign high_o = addr_i[0];
  assign idx_o  = addr_i[IDX_W:1];
  assign hit_o  = {1'b0, idx_o} < NREGS;

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_sel
    assign sel_o[k] = hit_o && (idx_o == k[IDX_W-1:0]);
  end
endmodule

// File: rtl/wrb_temp_reg.sv
module wrb_temp_reg
  import wrb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hi_wr_i,
  input  logic  lo_rd_i,
  input  byte_t wdata_i,
  input  byte_t hi_src_i,
  output byte_t temp_o
);
  byte_t temp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      temp_q <= '0;
    else if (hi_wr_i) temp_q <= wdata_i;
    else if (lo_rd_i) temp_q <= hi_src_i;
  end

  assign temp_o = temp_q;

  assert_hi_wr_loads_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr_i |=> temp_q == $past(wdata_i));
  assert_lo_rd_snaps_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_rd_i |=> temp_q == $past(hi_src_i));
  assert_idle_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_wr_i && !lo_rd_i) |=> $stable(temp_q));
  assert_one_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({hi_wr_i, lo_rd_i}));
endmodule

// File: rtl/wrb_read_mux.sv
module wrb_read_mux
  import wrb_pkg::*;
#(
  parameter int                     NUM_REGS = 4,
  parameter int                     IDX_W    = 2,
  parameter logic [NUM_REGS-1:0]    CMP_MASK = 4'b0110
) (
  input  logic             hit_i,
  input  logic             high_i,
  input  logic [IDX_W-1:0] idx_i,
  input  byte_t            temp_i,
  input  wide_t            vals_i [NUM_REGS],
  output byte_t            rdata_o,
  output byte_t            hi_src_o,
  output logic             is_cmp_o
);
  wide_t sel_val;

  always_comb begin
    sel_val  = hit_i ? vals_i[idx_i] : '0;
    is_cmp_o = hit_i && CMP_MASK[idx_i];
    hi_src_o = sel_val[WIDE_W-1:BYTE_W];
    if (!hit_i)      rdata_o = '0;
    else if (!high_i) rdata_o = sel_val[BYTE_W-1:0];
    else if (is_cmp_o) rdata_o = sel_val[WIDE_W-1:BYTE_W];
    else              rdata_o = temp_i;
  end
endmodule

// File: rtl/wide_reg_byte_bridge.sv
module wide_reg_byte_bridge
  import wrb_pkg::*;
#(
  parameter int                  NUM_REGS = 4,
  parameter logic [NUM_REGS-1:0] CMP_MASK = 4'b0110,
  localparam int IDX_W  = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       wr_i,
  input  logic                       rd_i,
  output logic [7:0]                 rdata_o,
  output logic [16*NUM_REGS-1:0]     reg_wdata_o,
  output logic [NUM_REGS-1:0]        reg_we_o,
  input  logic [16*NUM_REGS-1:0]     reg_val_i
);
  logic             hit, high, is_cmp;
  logic [IDX_W-1:0] idx;
  logic [NUM_REGS-1:0] sel;
  byte_t temp, hi_src;
  wide_t vals [NUM_REGS];
  logic  hi_wr, lo_wr, lo_rd_load;

  wrb_decode #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
    .addr_i (addr_i), .hit_o (hit), .high_o (high), .idx_o (idx), .sel_o (sel)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    assign vals[k] = reg_val_i[k*WIDE_W +: WIDE_W];
    assign reg_we_o[k] = lo_wr && sel[k];
    assign reg_wdata_o[k*WIDE_W +: WIDE_W] = {temp, wdata_i};
  end

  wrb_read_mux #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .CMP_MASK(CMP_MASK)) u_mux (
    .hit_i (hit), .high_i (high), .idx_i (idx), .temp_i (temp), .vals_i (vals),
    .rdata_o (rdata_o), .hi_src_o (hi_src), .is_cmp_o (is_cmp)
  );

  assign hi_wr      = wr_i && hit && high;
  assign lo_wr      = wr_i && hit && !high;
  // compare registers bypass the holding register on reads
  assign lo_rd_load = rd_i && hit && !high && !is_cmp;

  wrb_temp_reg u_temp (
    .clk_i (clk_i), .rst_ni (rst_ni), .hi_wr_i (hi_wr), .lo_rd_i (lo_rd_load),
    .wdata_i (wdata_i), .hi_src_i (hi_src), .temp_o (temp)
  );

  assert_we_onehot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(reg_we_o));
  assert_we_needs_low_wr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|reg_we_o) |-> (wr_i && !addr_i[0]));
  assert_no_we_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |-> reg_we_o == '0);
  assert_hi_read_temp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && high && !is_cmp) |-> rdata_o == temp);
  assert_cmp_keeps_temp_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && hit && !high && is_cmp) |=> $stable(temp));
endmodule

// File: tb/wide_reg_byte_bridge_tb_top.sv
module wide_reg_byte_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;
  localparam logic [NR-1:0] CMP = 4'b0110;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic wr = 0, rd = 0;
  logic [7:0] rdata;
  logic [16*NR-1:0] reg_wdata, reg_val;
  logic [NR-1:0] reg_we;

  logic [15:0] regs [NR] = '{16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h1728};
  logic [15:0] mdl [NR]  = '{16'hA1B2, 16'hC3D4, 16'hE5F6, 16'h1728};
  logic [7:0] mdl_temp = 0;
  logic ext_en = 0;
  int ext_idx = 0;
  logic [15:0] ext_val = 0;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_reg_byte_bridge #(.NUM_REGS(NR), .CMP_MASK(CMP)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .addr_i (addr), .wdata_i (wdata),
    .wr_i (wr), .rd_i (rd), .rdata_o (rdata), .reg_wdata_o (reg_wdata),
    .reg_we_o (reg_we), .reg_val_i (reg_val)
  );

  always_comb for (int k = 0; k < NR; k++) reg_val[k*16 +: 16] = regs[k];

  always @(posedge clk) begin
    for (int k = 0; k < NR; k++) if (reg_we[k]) regs[k] <= reg_wdata[k*16 +: 16];
    if (ext_en) regs[ext_idx] <= ext_val;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one bus cycle; expectations from the bench model
  task automatic op(input int idx, input bit hi, input logic [7:0] wd,
                    input bit w, input bit r, input string tag);
    logic [7:0] exp_rd;
    logic [NR-1:0] exp_we;
    logic [7:0] new_temp;
    @(negedge clk);
    addr = {idx[1:0], hi}; wdata = wd; wr = w; rd = r;
    #1;
    exp_rd = !hi ? mdl[idx][7:0] : (CMP[idx] ? mdl[idx][15:8] : mdl_temp);
    exp_we = (w && !hi) ? NR'(1 << idx) : '0;
    chk(rdata == exp_rd, {tag, " rdata"}, 32'(rdata), 32'(exp_rd));
    chk(reg_we == exp_we, {tag, " we"}, 32'(reg_we), 32'(exp_we));
    if (w && !hi)
      chk(reg_wdata[idx*16 +: 16] == {mdl_temp, wd}, {tag, " wdata"},
          32'(reg_wdata[idx*16 +: 16]), 32'({mdl_temp, wd}));
    new_temp = mdl_temp;
    if (w && hi) new_temp = wd;
    if (r && !hi && !CMP[idx]) new_temp = mdl[idx][15:8];
    if (w && !hi) mdl[idx] = {mdl_temp, wd};
    mdl_temp = new_temp;
    @(posedge clk); #1;
    wr = 0; rd = 0;
  endtask

  task automatic ext_set(input int idx, input logic [15:0] v);
    @(negedge clk);
    ext_en = 1; ext_idx = idx; ext_val = v;
    @(posedge clk); #1;
    ext_en = 0;
    mdl[idx] = v;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: holding register cleared
    op(0, 1, 8'h00, 0, 0, "R1 reset temp");
    op(3, 1, 8'h00, 0, 0, "R1 reset temp capture");
    // R2..R6 sweep over registers and values
    for (int r = 0; r < NR; r++) begin
      for (int i = 0; i < 6; i++) begin
        logic [15:0] v;
        v = 16'(r * 16'h3C5A + i * 16'h1357 + 16'h0101);
        op(r, 1, v[15:8], 1, 0, "R3 hi write");
        op(0, 1, 8'h00, 0, 0, "R6 hi read temp");
        op(r, 0, v[7:0], 1, 0, "R4 lo write");
        op(r, 0, 8'h00, 0, 1, "R5 lo read");
        op(r, 1, 8'h00, 0, 1, "R2 hi read");
      end
    end
    // R8: upper byte written via capture address, used by counter
    op(3, 1, 8'h9C, 1, 0, "R8 hi via r3");
    op(0, 0, 8'h47, 1, 0, "R8 lo to r0");
    op(2, 1, 8'h3E, 1, 0, "R8 hi via r2");
    op(1, 0, 8'h81, 1, 0, "R8 lo to r1");
    op(1, 1, 8'h00, 0, 1, "R8 readback cmp");
    // R7: compare reads bypass holding register
    op(0, 1, 8'h5A, 1, 0, "R7 set temp");
    op(1, 0, 8'h00, 0, 1, "R7 cmp lo read");
    op(0, 1, 8'h00, 0, 1, "R7 temp unchanged");
    op(2, 1, 8'h00, 0, 1, "R7 cmp live hi");
    ext_set(2, 16'hBEEF);
    op(2, 1, 8'h00, 0, 1, "R7 cmp live hi after change");
    // R5: snapshot survives a later change
    op(3, 0, 8'h00, 0, 1, "R5 snap lo");
    ext_set(3, 16'h6D2C);
    op(3, 1, 8'h00, 0, 1, "R5 snap hi old");
    op(3, 0, 8'h00, 0, 1, "R5 resnap lo");
    op(3, 1, 8'h00, 0, 1, "R5 resnap hi new");
    // R9: write and read together on counter lower byte
    op(0, 1, 8'hD7, 1, 0, "R9 prime temp");
    op(0, 0, 8'h19, 1, 1, "R9 overlap");
    op(0, 1, 8'h00, 0, 1, "R9 temp holds old hi");
    op(0, 0, 8'h00, 0, 1, "R9 new value lo");
    op(0, 1, 8'h00, 0, 1, "R9 new value hi");
    // R10: no strobes, address sweep
    op(3, 1, 8'h77, 1, 0, "R10 set temp");
    for (int a = 0; a < 2 * NR; a++) op(a / 2, a[0], 8'hFF, 0, 0, "R10 idle sweep");
    op(0, 1, 8'h00, 0, 0, "R10 temp stable");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule